// File: doc/BRIEF.md
# Merging Multi-Line Write Buffer

This block sits between a processor's data-write port and a split-transaction bus initiator. Processor word writes are posted into a small set of line-sized slots, where consecutive writes to one cache line are merged byte by byte. Each closed slot is then emitted as a single burst of contiguous ascending word addresses. The processor is stalled only when a write can neither join the slot it is filling nor claim a free one.

Several slots may be on the bus at once. Each burst carries an odd transaction ID derived from its slot number. Responses return in any order and free the slot named by their ID. A read path can query whether a line still has a write pending, and a sync operation can wait on the empty flag.

Top module: `merge_wbuf`

## Requirements
- R1: A write joins the slot filled by the immediately preceding accepted write only if both are cached, they target the same line, and no cycle without a joining write has passed in between. Any other accepted write claims a new slot, including a write to a line whose slot has already been sent.
- R2: A burst covers the slot's word offsets from the lowest present word to the highest, in ascending order. Each beat's address is the previous one plus the word size. Absent words inside that span are emitted with all byte enables clear, and `cmd_last` marks the highest present word.
- R3: Within a slot, each byte lane of a word holds the data of the latest write that had that lane's enable set. The beat's byte enables are the OR of all enables written to that word, so a second full-word write to a word replaces the first.
- R4: An uncached write never shares a slot. It is emitted as a one-beat burst with `cmd_last` set.
- R5: A slot's burst carries ID 2*slot+1, and a new slot is always the lowest-numbered free one.
- R6: A slot closes at the end of the first cycle in which no write joins it. Closed slots are emitted in the order they closed, and a beat is held unchanged while `cmd_valid` is high and `cmd_ready` is low.
- R7: A response with `rsp_valid` high frees the sent slot whose ID it carries, in any order, and the freed slot can be used again.
- R8: `chk_hit` is high in the same cycle when the line of `chk_addr` equals the line of any slot that is not free.
- R9: `wr_ready` is low exactly when the write cannot join the current slot and no slot is free.
- R10: `empty` is high exactly when every slot is free.
- R11: A response with `rsp_err` high sets `wr_err`, which stays set until reset, and the slot is still freed.
- R12: After reset, all slots are free: `empty` is 1, `cmd_valid` is 0, `wr_err` is 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor write request |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte enables |
| wr_uncached | input | 1 | Write must go out on its own |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| cmd_valid | output | 1 | Burst beat available |
| cmd_ready | input | 1 | Bus takes the beat |
| cmd_addr | output | ADDR_W | Beat byte address |
| cmd_data | output | DATA_W | Beat data |
| cmd_be | output | DATA_W/8 | Beat byte enables |
| cmd_last | output | 1 | Final beat of the burst |
| cmd_id | output | ID_W | Transaction ID, 2*slot+1 |
| rsp_valid | input | 1 | Write response arrives |
| rsp_id | input | ID_W | ID of the completed burst |
| rsp_err | input | 1 | Response reports an error |
| chk_addr | input | ADDR_W | Address probed by a read miss |
| chk_hit | output | 1 | Probed line has a pending write |
| empty | output | 1 | No slot occupied |
| wr_err | output | 1 | Sticky write-error flag |

## Verification
The bench uses the default parameters: four slots, four-word lines and 32-bit words. With four slots, a handful of writes exhausts the buffer, so the stall path, out-of-order release and slot reuse can all be reached in a short run. A four-word line is wide enough to place a hole between two present words and to show reordering across three offsets. Under these parameters the IDs take the values 1, 3, 5 and 7, which the reference model predicts from its own free-slot choice.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_OPEN  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_SENT  = 2'd3
    } slot_state_e;
endpackage

// File: rtl/wbuf_prio.sv
// Priority pick over a request vector; FROM_TOP selects highest instead of lowest.
module wbuf_prio #(
    parameter int N        = 4,
    parameter int IW       = 2,
    parameter bit FROM_TOP = 1'b0
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    assign found = |req;
    generate
        if (FROM_TOP) begin : g_high
            always_comb begin
                idx = '0;
                for (int i = 0; i < N; i++)
                    if (req[i]) idx = IW'(i);
            end
        end else begin : g_low
            always_comb begin
                idx = '0;
                for (int i = N - 1; i >= 0; i--)
                    if (req[i]) idx = IW'(i);
            end
        end
    endgenerate
endmodule

// File: rtl/wbuf_line_cam.sv
// Line-address compare against every occupied slot.
module wbuf_line_cam #(
    parameter int N = 4,
    parameter int W = 28
) (
    input  logic [N-1:0]        vld,
    input  logic [N-1:0][W-1:0] lines,
    input  logic [W-1:0]        key,
    output logic                hit
);
    logic [N-1:0] match;
    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g] = vld[g] && (lines[g] == key);
        end
    endgenerate
    assign hit = |match;
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NSLOTS     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [DATA_W/8-1:0]           wr_be,
    input  logic                          wr_uncached,
    output logic                          wr_ready,
    output logic                          cmd_valid,
    input  logic                          cmd_ready,
    output logic [ADDR_W-1:0]             cmd_addr,
    output logic [DATA_W-1:0]             cmd_data,
    output logic [DATA_W/8-1:0]           cmd_be,
    output logic                          cmd_last,
    output logic [((NSLOTS > 1) ? $clog2(NSLOTS) : 1):0] cmd_id,
    input  logic                          rsp_valid,
    input  logic [((NSLOTS > 1) ? $clog2(NSLOTS) : 1):0] rsp_id,
    input  logic                          rsp_err,
    input  logic [ADDR_W-1:0]             chk_addr,
    output logic                          chk_hit,
    output logic                          empty,
    output logic                          wr_err
);
    import wbuf_pkg::*;

    localparam int BE_W   = DATA_W / 8;
    localparam int BOFF   = $clog2(BE_W);
    localparam int WOFF   = $clog2(LINE_WORDS);
    localparam int LINE_W = ADDR_W - WOFF - BOFF;
    localparam int IDX_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
    localparam int ID_W   = IDX_W + 1;
    localparam int CNT_W  = IDX_W + 1;

    typedef struct packed {
        logic [NSLOTS-1:0][1:0]                        st;
        logic [NSLOTS-1:0][LINE_W-1:0]                 line;
        logic [NSLOTS-1:0][LINE_WORDS-1:0][DATA_W-1:0] data;
        logic [NSLOTS-1:0][LINE_WORDS-1:0][BE_W-1:0]   be;
        logic [NSLOTS-1:0][IDX_W-1:0]                  rq;
        logic [IDX_W-1:0]                              rq_head;
        logic [IDX_W-1:0]                              rq_tail;
        logic [CNT_W-1:0]                              rq_cnt;
        logic                                          open_vld;
        logic                                          open_unc;
        logic [IDX_W-1:0]                              open_idx;
        logic                                          cmd_act;
        logic [WOFF-1:0]                               cmd_ptr;
        logic                                          err;
    } state_t;

    state_t q, d;

    function automatic logic [IDX_W-1:0] ptr_inc(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NSLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [LINE_W-1:0]     wr_line;
    logic [WOFF-1:0]       wr_word;
    logic [NSLOTS-1:0]     free_mask;
    logic                  free_found;
    logic [IDX_W-1:0]      free_idx;
    logic                  join_ok;
    logic                  wr_fire;
    logic [IDX_W-1:0]      tgt;
    logic [IDX_W-1:0]      head;
    logic                  rq_nempty;
    logic [LINE_WORDS-1:0] head_pres;
    logic                  head_any_lo, head_any_hi;
    logic [WOFF-1:0]       head_first, head_last;
    logic [WOFF-1:0]       cur;
    logic                  push, pop;
    logic [IDX_W-1:0]      rsp_slot;

    assign wr_line  = wr_addr[ADDR_W-1 -: LINE_W];
    assign wr_word  = wr_addr[BOFF +: WOFF];
    assign head     = q.rq[q.rq_head];
    assign rq_nempty = (q.rq_cnt != '0);
    assign rsp_slot = rsp_id[ID_W-1:1];

    always_comb begin
        for (int i = 0; i < NSLOTS; i++) free_mask[i] = (q.st[i] == SLOT_FREE);
        for (int w = 0; w < LINE_WORDS; w++) head_pres[w] = |q.be[head][w];
    end

    wbuf_prio #(.N(NSLOTS), .IW(IDX_W), .FROM_TOP(1'b0)) u_free_pick (
        .req(free_mask), .found(free_found), .idx(free_idx));
    wbuf_prio #(.N(LINE_WORDS), .IW(WOFF), .FROM_TOP(1'b0)) u_first_word (
        .req(head_pres), .found(head_any_lo), .idx(head_first));
    wbuf_prio #(.N(LINE_WORDS), .IW(WOFF), .FROM_TOP(1'b1)) u_last_word (
        .req(head_pres), .found(head_any_hi), .idx(head_last));
    wbuf_line_cam #(.N(NSLOTS), .W(LINE_W)) u_hazard (
        .vld(~free_mask), .lines(q.line), .key(chk_addr[ADDR_W-1 -: LINE_W]), .hit(chk_hit));

    assign join_ok  = wr_valid && !wr_uncached && q.open_vld && !q.open_unc
                      && (q.line[q.open_idx] == wr_line);
    assign wr_ready = join_ok || free_found;
    assign wr_fire  = wr_valid && wr_ready;
    assign tgt      = join_ok ? q.open_idx : free_idx;
    assign cur      = q.cmd_act ? q.cmd_ptr : head_first;

    assign cmd_valid = rq_nempty;
    assign cmd_addr  = {q.line[head], cur, {BOFF{1'b0}}};
    assign cmd_data  = q.data[head][cur];
    assign cmd_be    = q.be[head][cur];
    assign cmd_last  = (cur == head_last);
    assign cmd_id    = {head, 1'b1};
    assign empty     = &free_mask;
    assign wr_err    = q.err;

    logic unused_bits;
    assign unused_bits = ^{wr_addr[BOFF-1:0], chk_addr[ADDR_W-LINE_W-1:0], rsp_id[0],
                           head_any_lo, head_any_hi};

    always_comb begin
        d    = q;
        push = 1'b0;
        pop  = 1'b0;

        // response: release a sent slot by its ID
        if (rsp_valid && (q.st[rsp_slot] == SLOT_SENT)) begin
            d.st[rsp_slot] = SLOT_FREE;
            if (rsp_err) d.err = 1'b1;
        end

        // command side: stream the head slot
        if (rq_nempty && cmd_ready) begin
            if (cur == head_last) begin
                d.st[head] = SLOT_SENT;
                d.rq_head  = ptr_inc(q.rq_head);
                d.cmd_act  = 1'b0;
                pop        = 1'b1;
            end else begin
                d.cmd_act  = 1'b1;
                d.cmd_ptr  = cur + 1'b1;
            end
        end

        // close the filling slot unless this write joins it
        if (q.open_vld && !(wr_fire && join_ok)) begin
            d.st[q.open_idx] = SLOT_READY;
            d.rq[q.rq_tail]  = q.open_idx;
            d.rq_tail        = ptr_inc(q.rq_tail);
            push             = 1'b1;
        end

        // processor write: claim or join, then merge byte lanes
        if (wr_fire) begin
            if (!join_ok) begin
                d.st[tgt]   = SLOT_OPEN;
                d.line[tgt] = wr_line;
                d.be[tgt]   = '0;
            end
            for (int b = 0; b < BE_W; b++)
                if (wr_be[b]) d.data[tgt][wr_word][b*8 +: 8] = wr_data[b*8 +: 8];
            d.be[tgt][wr_word] = d.be[tgt][wr_word] | wr_be;
            d.open_vld = 1'b1;
            d.open_idx = tgt;
            d.open_unc = wr_uncached;
        end else begin
            d.open_vld = 1'b0;
        end

        d.rq_cnt = q.rq_cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ID_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ready,
    input logic              empty,
    input logic              chk_hit,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic [ID_W-1:0]   cmd_id,
    input logic              cmd_last,
    input logic              wr_err
);
    localparam int WB = DATA_W / 8;

    // R2: beats of one burst step up by one word under the same ID
    assert_burst_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && !cmd_last |=>
        cmd_valid && (cmd_addr == $past(cmd_addr) + ADDR_W'(WB)) && $stable(cmd_id));

    // R6: a stalled beat is held
    assert_beat_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=>
        cmd_valid && $stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_id) && $stable(cmd_last));

    // R9: a stall only happens with slots occupied
    assert_stall_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> !empty);

    // R10: an empty buffer has nothing to send and nothing to match
    assert_empty_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !cmd_valid && !chk_hit);

    // R11: the error flag never drops outside reset
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);
endmodule

bind merge_wbuf merge_wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .empty(empty), .chk_hit(chk_hit),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_id(cmd_id), .cmd_last(cmd_last), .wr_err(wr_err));

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int LW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_uncached = 1'b0;
    logic        wr_ready;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_be;
    logic        cmd_last;
    logic [2:0]  cmd_id;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_id = '0;
    logic        rsp_err = 1'b0;
    logic [31:0] chk_addr = '0;
    logic        chk_hit;
    logic        empty;
    logic        wr_err;

    int errors = 0;
    int checks = 0;

    merge_wbuf #(.ADDR_W(32), .DATA_W(32), .LINE_WORDS(LW), .NSLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .wr_uncached(wr_uncached), .wr_ready(wr_ready), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_be(cmd_be),
        .cmd_last(cmd_last), .cmd_id(cmd_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .rsp_err(rsp_err), .chk_addr(chk_addr), .chk_hit(chk_hit), .empty(empty), .wr_err(wr_err));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int          st[NS];          // 0 free, 1 filling, 2 closed, 3 on bus
    int          ln[NS];
    logic [31:0] md[NS][LW];
    logic [3:0]  mb[NS][LW];
    int          rq[$];
    int          open_s = -1;
    bit          open_u = 0;
    bit          merr = 0;
    int          mptr = -1;
    bit          e_join, e_ready;
    int          e_free, e_s, e_first, e_last, e_cur;

    function automatic int line_of(input logic [31:0] a); return int'(a >> 4); endfunction
    function automatic int word_of(input logic [31:0] a); return int'((a >> 2) & 32'd3); endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic eval_expect();
        e_join = wr_valid && !wr_uncached && open_s >= 0 && !open_u && ln[open_s] == line_of(wr_addr);
        e_free = -1;
        for (int i = NS - 1; i >= 0; i--) if (st[i] == 0) e_free = i;
        e_ready = e_join || (e_free >= 0);
        e_s = -1; e_first = 0; e_last = 0; e_cur = 0;
        if (rq.size() > 0) begin
            e_s = rq[0];
            e_first = -1;
            for (int w = 0; w < LW; w++) if (mb[e_s][w] != 0) begin
                if (e_first < 0) e_first = w;
                e_last = w;
            end
            e_cur = (mptr < 0) ? e_first : mptr;
        end
    endtask

    task automatic compare_all();
        bit any = 0, hit = 0;
        for (int i = 0; i < NS; i++) begin
            if (st[i] != 0) any = 1;
            if (st[i] != 0 && ln[i] == line_of(chk_addr)) hit = 1;
        end
        chk("R9 wr_ready", 64'(wr_ready), 64'(e_ready));
        chk("R10 empty", 64'(empty), 64'(!any));
        chk("R8 chk_hit", 64'(chk_hit), 64'(hit));
        chk("R11 wr_err", 64'(wr_err), 64'(merr));
        chk("R6 cmd_valid", 64'(cmd_valid), 64'(rq.size() > 0));
        if (rq.size() > 0 && cmd_valid) begin
            chk("R2 cmd_addr", 64'(cmd_addr), 64'((ln[e_s] << 4) | (e_cur << 2)));
            chk("R3 cmd_be", 64'(cmd_be), 64'(mb[e_s][e_cur]));
            if (mb[e_s][e_cur] != 0) begin
                for (int b = 0; b < 4; b++)
                    if (mb[e_s][e_cur][b])
                        chk("R3 cmd_data byte", 64'(cmd_data[b*8 +: 8]), 64'(md[e_s][e_cur][b*8 +: 8]));
            end
            chk("R2 cmd_last", 64'(cmd_last), 64'(e_cur == e_last));
            chk("R5 cmd_id", 64'(cmd_id), 64'(2 * e_s + 1));
        end
    endtask

    task automatic model_update();
        bit fire;
        int t, wd;
        fire = wr_valid && e_ready;
        if (rsp_valid && st[rsp_id >> 1] == 3) begin
            st[rsp_id >> 1] = 0;
            if (rsp_err) merr = 1;
        end
        if (rq.size() > 0 && cmd_ready) begin
            if (e_cur == e_last) begin
                st[e_s] = 3;
                void'(rq.pop_front());
                mptr = -1;
            end else mptr = e_cur + 1;
        end
        if (open_s >= 0 && !(fire && e_join)) begin
            st[open_s] = 2;
            rq.push_back(open_s);
        end
        if (fire) begin
            t = e_join ? open_s : e_free;
            if (!e_join) begin
                st[t] = 1;
                ln[t] = line_of(wr_addr);
                for (int w = 0; w < LW; w++) mb[t][w] = '0;
            end
            wd = word_of(wr_addr);
            for (int b = 0; b < 4; b++)
                if (wr_be[b]) md[t][wd][b*8 +: 8] = wr_data[b*8 +: 8];
            mb[t][wd] = mb[t][wd] | wr_be;
            open_s = t;
            open_u = wr_uncached;
        end else open_s = -1;
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic step();
        #1;
        eval_expect();
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] dt, input logic [3:0] be, input bit unc);
        wr_valid = 1; wr_addr = a; wr_data = dt; wr_be = be; wr_uncached = unc;
        step();
        wr_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic rsp(input int id, input bit e);
        rsp_valid = 1; rsp_id = 3'(id); rsp_err = e;
        step();
        rsp_valid = 0; rsp_err = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            st[i] = 0; ln[i] = 0;
            for (int w = 0; w < LW; w++) begin md[i][w] = '0; mb[i][w] = '0; end
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R12 empty after reset", 64'(empty), 64'd1);
        chk("R12 cmd_valid after reset", 64'(cmd_valid), 64'd0);
        chk("R12 wr_err after reset", 64'(wr_err), 64'd0);
        chk("R12 wr_ready after reset", 64'(wr_ready), 64'd1);
        @(negedge clk);
        rst_n = 1;

        // reorder, hole and byte merge within one line
        wr(32'h10C, 32'h33333333, 4'hF, 0);
        wr(32'h104, 32'h11111111, 4'hF, 0);
        wr(32'h104, 32'h000000AA, 4'h1, 0);
        wr(32'h104, 32'hBB000000, 4'h8, 0);
        idle(1);
        #1;
        chk("R1 R2 first beat is lowest word", 64'(cmd_addr), 64'h104);
        chk("R3 merged word", 64'(cmd_data), 64'hBB1111AA);
        chk("R5 first slot id", 64'(cmd_id), 64'd1);

        // non-consecutive same-line write, then fill every slot
        wr(32'h108, 32'h44444444, 4'hF, 0);
        wr(32'h300, 32'h55555555, 4'hF, 0);
        wr(32'h104, 32'h66666666, 4'hF, 0);
        wr_valid = 1; wr_addr = 32'h400; wr_data = 32'h77777777; wr_be = 4'hF; wr_uncached = 0;
        chk_addr = 32'h108;
        #1;
        chk("R9 stall with all slots taken", 64'(wr_ready), 64'd0);
        chk("R8 pending line match", 64'(chk_hit), 64'd1);
        step();
        step();
        wr_valid = 0;
        idle(1);
        chk_addr = 32'h500;
        #1;
        chk("R8 no match on other line", 64'(chk_hit), 64'd0);
        cmd_ready = 1;
        idle(10);

        // out-of-order release, one with error
        rsp(5, 0);
        #1;
        chk("R7 slots still held", 64'(empty), 64'd0);
        rsp(1, 1);
        rsp(7, 0);
        rsp(3, 0);
        idle(1);
        #1;
        chk("R10 all released", 64'(empty), 64'd1);
        chk("R11 error kept", 64'(wr_err), 64'd1);

        // uncached writes never merge
        cmd_ready = 0;
        wr(32'h200, 32'hA0A0A0A0, 4'hF, 1);
        wr(32'h204, 32'hB0B0B0B0, 4'hF, 1);
        idle(1);
        #1;
        chk("R4 uncached single beat addr", 64'(cmd_addr), 64'h200);
        chk("R4 uncached single beat last", 64'(cmd_last), 64'd1);
        idle(2);
        cmd_ready = 1;
        idle(4);
        rsp(3, 0);
        rsp(1, 0);

        // full-word overwrite and partial merge
        wr(32'h600, 32'h11111111, 4'hF, 0);
        wr(32'h600, 32'h22222222, 4'hF, 0);
        wr(32'h604, 32'h0000CC00, 4'h2, 0);
        wr(32'h604, 32'h000000DD, 4'h1, 0);
        idle(4);
        rsp(1, 0);

        // write to a line already on the bus opens a fresh slot
        wr(32'h700, 32'h12345678, 4'hF, 0);
        idle(2);
        wr(32'h704, 32'h9ABCDEF0, 4'hF, 0);
        idle(1);
        #1;
        chk("R1 sent line not rejoined", 64'(cmd_id), 64'd3);
        idle(2);
        rsp(3, 0);
        rsp(1, 0);
        idle(2);
        #1;
        chk("R7 slots reusable and freed", 64'(empty), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule